// File: doc/BRIEF.md
# Early-Late Quarter-Phase Picker

This block is the digital core of a feed-forward clock phase aligner for bursty serial data. Once per recovered-clock bit period it takes three samples from a reference clock: the bit before, the bit now, and an edge sample taken where a transition is expected. It also takes two extra copies of the current bit. One copy is sampled a quarter period before the reference clock and the other a quarter period after it. The block makes a bang-bang early/late decision on the three reference samples. It then forwards one of the two quarter-shifted copies as retimed data.

The decision does not steer a loop. It picks the copy to use straight away, bit by bit. It needs no preamble and no knowledge of a start-of-packet pattern. When the samples carry no phase information (a run of identical bits) or contradict each other, the previous choice is kept. A burst-start input returns the choice to the early quarter-phase copy. The registered outputs are the retimed bit, a two-bit decision status and a flag that shows which copy is in use.

Top module: `early_late_picker`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, data_o, status_o and sel_plus_o are all 0.
- R2: One clock edge after the samples are taken, status_o equals {edge^cur, prev^edge} of those samples. Code 2'b01 means the reference clock is late, 2'b10 means it is early, 2'b00 means no transition, and 2'b11 means undecided.
- R3: A late code (2'b01) with burst_start_i low sets sel_plus_o to 0 at the next edge. This selects the copy taken a quarter period early.
- R4: An early code (2'b10) with burst_start_i low sets sel_plus_o to 1 at the next edge. This selects the copy taken a quarter period late.
- R5: A no-transition code (2'b00) with burst_start_i low leaves sel_plus_o unchanged.
- R6: An undecided code (2'b11) with burst_start_i low leaves sel_plus_o unchanged.
- R7: burst_start_i high sets sel_plus_o to 0 at the next edge, whatever the samples show.
- R8: At each edge, data_o takes smp_pq_i if the new sel_plus_o is 1, and smp_mq_i otherwise, using the samples of that same edge. The latency is one cycle.
- R9: In a burst that starts with burst_start_i and has a constant phase offset, data_o equals the transmitted bit in every cycle from the first bit transition onward. The copy on the wrong side of the eye may carry any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_start_i | input | 1 | Marks the first bit of a new burst |
| smp_prev_i | input | 1 | Reference sample of the previous bit |
| smp_edge_i | input | 1 | Reference sample at the expected transition |
| smp_cur_i | input | 1 | Reference sample of the current bit |
| smp_mq_i | input | 1 | Current bit sampled a quarter period early |
| smp_pq_i | input | 1 | Current bit sampled a quarter period late |
| data_o | output | 1 | Retimed data bit |
| status_o | output | 2 | Decision code: 01 late, 10 early, 00 no transition, 11 undecided |
| sel_plus_o | output | 1 | 1 when the late quarter-phase copy is in use |

## Verification
Three things can land on the same edge: the new phase choice, the retiming of the data through that choice, and a burst-start override. The bench sweeps every sample combination with burst_start_i both low and high, starting from each prior selection. So an early decision and a burst start coincide on purpose, and a change of selection coincides with the data it must retime. Each result is judged against a bench model built from the requirements. The model checks that data_o follows the newly chosen copy and not the old one, and that the burst start wins over the early decision.

// File: rtl/elp_pkg.sv
package elp_pkg;
  localparam int unsigned STATUS_W = 2;

  typedef enum logic [STATUS_W-1:0] {
    ST_CID   = 2'b00,
    ST_LATE  = 2'b01,
    ST_EARLY = 2'b10,
    ST_UNDEC = 2'b11
  } status_e;

  localparam logic SEL_MINUS = 1'b0;
  localparam logic SEL_PLUS  = 1'b1;
endpackage

// File: rtl/elp_classify.sv
module elp_classify
  import elp_pkg::*;
(
  input  logic    prev_i,
  input  logic    edge_i,
  input  logic    cur_i,
  output status_e status_o
);
  logic x_d, y_d;
  assign x_d = edge_i ^ cur_i;
  assign y_d = prev_i ^ edge_i;
  assign status_o = status_e'({x_d, y_d});
endmodule

// File: rtl/elp_phase_hold.sv
module elp_phase_hold
  import elp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    burst_start_i,
  input  status_e status_i,
  output logic    sel_next_o,
  output logic    sel_q_o
);
  always_comb begin
    sel_next_o = sel_q_o;
    if (burst_start_i) sel_next_o = SEL_MINUS;
    else begin
      unique case (status_i)
        ST_LATE:  sel_next_o = SEL_MINUS;
        ST_EARLY: sel_next_o = SEL_PLUS;
        default:  sel_next_o = sel_q_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q_o <= SEL_MINUS;
    else         sel_q_o <= sel_next_o;
  end

  // R3
  late_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == ST_LATE && !burst_start_i) |=> (sel_q_o == SEL_MINUS));
  // R4
  early_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == ST_EARLY && !burst_start_i) |=> (sel_q_o == SEL_PLUS));
  // R5
  cid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == ST_CID && !burst_start_i) |=> $stable(sel_q_o));
  // R6
  undec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == ST_UNDEC && !burst_start_i) |=> $stable(sel_q_o));
  // R7
  burst_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_i |=> (sel_q_o == SEL_MINUS));
endmodule

// File: rtl/elp_retime.sv
module elp_retime
  import elp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                smp_mq_i,
  input  logic                smp_pq_i,
  input  status_e             status_i,
  output logic                data_o,
  output logic [STATUS_W-1:0] status_o
);
  logic pick_d;
  assign pick_d = (sel_i == SEL_PLUS) ? smp_pq_i : smp_mq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= 1'b0;
      status_o <= ST_CID;
    end else begin
      data_o   <= pick_d;
      status_o <= status_i;
    end
  end
endmodule

// File: rtl/early_late_picker.sv
module early_late_picker
  import elp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                burst_start_i,
  input  logic                smp_prev_i,
  input  logic                smp_edge_i,
  input  logic                smp_cur_i,
  input  logic                smp_mq_i,
  input  logic                smp_pq_i,
  output logic                data_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                sel_plus_o
);
  status_e status_d;
  logic    sel_next;
  logic    sel_q;

  elp_classify u_classify (
    .prev_i   (smp_prev_i),
    .edge_i   (smp_edge_i),
    .cur_i    (smp_cur_i),
    .status_o (status_d)
  );

  elp_phase_hold u_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .burst_start_i (burst_start_i),
    .status_i      (status_d),
    .sel_next_o    (sel_next),
    .sel_q_o       (sel_q)
  );

  elp_retime u_retime (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_next),
    .smp_mq_i (smp_mq_i),
    .smp_pq_i (smp_pq_i),
    .status_i (status_d),
    .data_o   (data_o),
    .status_o (status_o)
  );

  assign sel_plus_o = sel_q;

  // arms $past-based checks once a post-reset edge has passed
  logic chk_arm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_arm_q <= 1'b0;
    else         chk_arm_q <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (data_o == 1'b0 && status_o == 2'b00 && sel_plus_o == 1'b0));
  // R2
  status_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_arm_q)
    status_o == {$past(smp_edge_i ^ smp_cur_i), $past(smp_prev_i ^ smp_edge_i)});
  // R8
  retime_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_arm_q)
    data_o == (sel_plus_o ? $past(smp_pq_i) : $past(smp_mq_i)));
endmodule

// File: tb/early_late_picker_tb_top.sv
module early_late_picker_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic burst_start_i = 1'b0;
  logic smp_prev_i = 1'b0, smp_edge_i = 1'b0, smp_cur_i = 1'b0;
  logic smp_mq_i = 1'b0, smp_pq_i = 1'b0;
  logic data_o;
  logic [1:0] status_o;
  logic sel_plus_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  early_late_picker dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .burst_start_i(burst_start_i),
    .smp_prev_i(smp_prev_i), .smp_edge_i(smp_edge_i), .smp_cur_i(smp_cur_i),
    .smp_mq_i(smp_mq_i), .smp_pq_i(smp_pq_i),
    .data_o(data_o), .status_o(status_o), .sel_plus_o(sel_plus_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, read just after the capturing posedge
  task automatic step(input logic bs, input logic p, input logic e, input logic c,
                      input logic mq, input logic pq);
    @(negedge clk);
    burst_start_i = bs; smp_prev_i = p; smp_edge_i = e; smp_cur_i = c;
    smp_mq_i = mq; smp_pq_i = pq;
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #1;
    chk("R1 data", int'(data_o), 0);
    chk("R1 status", int'(status_o), 0);
    chk("R1 sel", int'(sel_plus_o), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 data", int'(data_o), 0);
    chk("R1 status", int'(status_o), 0);
    chk("R1 sel", int'(sel_plus_o), 0);

    // exhaustive sweep: prior selection x burst x 32 sample patterns
    for (int pri = 0; pri < 2; pri++) begin
      for (int bs = 0; bs < 2; bs++) begin
        for (int v = 0; v < 32; v++) begin
          logic p, e, c, mq, pq, xs, ys, es;
          int code, tag;
          // prime selection: late pattern -> minus, early pattern -> plus
          if (pri == 0) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
          else          step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
          chk("R3/R4 prime", int'(sel_plus_o), pri);
          p = v[4]; e = v[3]; c = v[2]; mq = v[1]; pq = v[0];
          step(logic'(bs), p, e, c, mq, pq);
          xs = e ^ c; ys = p ^ e;
          code = {xs, ys};
          if (bs == 1)        begin es = 1'b0;       tag = 7; end
          else if (code == 1) begin es = 1'b0;       tag = 3; end
          else if (code == 2) begin es = 1'b1;       tag = 4; end
          else if (code == 0) begin es = logic'(pri); tag = 5; end
          else                begin es = logic'(pri); tag = 6; end
          chk("R2 status", int'(status_o), code);
          case (tag)
            3: chk("R3 late sel", int'(sel_plus_o), int'(es));
            4: chk("R4 early sel", int'(sel_plus_o), int'(es));
            5: chk("R5 cid hold", int'(sel_plus_o), int'(es));
            6: chk("R6 undec hold", int'(sel_plus_o), int'(es));
            default: chk("R7 burst default", int'(sel_plus_o), int'(es));
          endcase
          chk("R8 data", int'(data_o), int'(es ? pq : mq));
        end
      end
    end

    // bursts with a constant phase offset; wrong-side copy is random
    for (int b = 0; b < 16; b++) begin
      logic late_clk, prev_bit, seen;
      late_clk = logic'(b % 2 == 0) ^ logic'($urandom_range(0, 1) & (b > 7));
      prev_bit = logic'($urandom_range(0, 1));
      seen = 1'b0;
      for (int k = 0; k < 40; k++) begin
        logic bit_k, edg, junk, mq, pq;
        bit_k = logic'($urandom_range(0, 1));
        if (k > 0 && bit_k != prev_bit) edg = late_clk ? bit_k : prev_bit;
        else                            edg = bit_k;
        junk = logic'($urandom_range(0, 1));
        mq = late_clk ? bit_k : junk;
        pq = late_clk ? junk : bit_k;
        step(logic'(k == 0), (k == 0) ? bit_k : prev_bit, edg, bit_k, mq, pq);
        if (k > 0 && bit_k != prev_bit) seen = 1'b1;
        if (seen) chk("R9 burst data", int'(data_o), int'(bit_k));
        prev_bit = bit_k;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule